// File: doc/BRIEF.md
# UART Low-Power Sequencer with Receive-Line Wake

This block wraps a plain 8N1 serial transmitter and receiver in the logic that handles the chip's sleep and idle states. The system supplies a sleep request, an idle request, a module enable, a stop-in-idle select, a wake arm and a receive-interrupt enable. When the block is halted, any frame in flight is dropped. The transmit line goes to its idle level, and the data and shift registers keep their contents.

If the block is armed and asleep, a falling edge on the receive line sets a wake flag through an edge-clocked flop. This path needs no running clock, so it can bring the system out of sleep. Software clears the flag once the system is awake. After any halt, the receiver starts again from idle and waits for a fresh start bit. It never resumes a partial frame.

Top module: `uart_pm_top`

## Requirements
- R1: After reset, tx_o is 1, tx_busy_o, tx_done_o, rx_busy_o, rx_valid_o, wake_irq_o and wake_o are 0, and rx_data_o is 0.
- R2: A tx_start_i pulse accepted while idle sends a start bit (0), then the 8 data bits LSB first, then a stop bit (1). Each bit lasts CLKS_PER_BIT cycles. tx_done_o pulses for one cycle as the frame ends, in the same cycle that tx_busy_o drops.
- R3: The receiver accepts a low level as a start bit only if the line is still low half a bit later. It samples the data bits mid-bit, LSB first. A stop bit of 1 loads rx_data_o and pulses rx_valid_o for one cycle. A stop bit of 0 discards the frame.
- R4: The block is halted when sleep_i is 1, when en_i is 0, or when idle_i and stop_in_idle_i are both 1. While halted, tx_o is 1 at once, and both busy flags are 0 from the next clock edge onward.
- R5: A frame cut short by a halt produces neither tx_done_o nor rx_valid_o.
- R6: rx_data_o keeps its value across a halt and changes only when a valid frame completes.
- R7: With stop_in_idle_i at 0, idle_i has no effect, and transfers complete normally.
- R8: A falling edge on rx_i while sleep_i, en_i and wake_en_i are all 1 sets wake_irq_o without any clock edge. The edge sets it whatever the value of rx_irq_en_i.
- R9: wake_o is 1 only while wake_irq_o, rx_irq_en_i and en_i are all 1.
- R10: wake_clr_i at 1, or reset, clears wake_irq_o immediately. A falling edge of rx_i while wake_en_i is 0 leaves it at 0.
- R11: After a halt or a framing error, the receiver needs the line to be high before it accepts a new start bit. A line that is already low when the halt ends does not start a frame.
- R12: tx_start_i is ignored while the transmitter is busy or the block is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock (stopped during sleep) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable |
| sleep_i | input | 1 | System sleep request |
| idle_i | input | 1 | System idle request |
| stop_in_idle_i | input | 1 | 1: halt while idle_i is 1 |
| wake_en_i | input | 1 | Arm the receive-line wake |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| wake_clr_i | input | 1 | Clear the wake flag |
| tx_data_i | input | DATA_W | Byte to send |
| tx_start_i | input | 1 | Start a frame |
| tx_o | output | 1 | Serial transmit line |
| tx_busy_o | output | 1 | Transmitter active |
| tx_done_o | output | 1 | Frame sent (one-cycle pulse) |
| rx_i | input | 1 | Serial receive line |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | Byte received (one-cycle pulse) |
| rx_busy_o | output | 1 | Receiver inside a frame |
| wake_irq_o | output | 1 | Wake flag |
| wake_o | output | 1 | Wake request to the system |

## Verification
The clocked assertions assume that the clock runs whenever halt changes. A halt that begins or ends while the clock is stopped is only seen at the next edge. The stimulus therefore always changes sleep_i and idle_i with the clock running, and stops the clock only during the wake tests. The receive checks assume that rx_i moves only on bit boundaries a whole number of cycles apart. The bench drives every serial frame on falling clock edges at exactly CLKS_PER_BIT cycles per bit.

// File: rtl/uart_pm_pkg.sv
`timescale 1ns/1ps
package uart_pm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} uart_st_e;
endpackage

// File: rtl/uart_pm_tx.sv
`timescale 1ns/1ps
module uart_pm_tx import uart_pm_pkg::*; #(
  parameter int CLKS_PER_BIT = 8,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  uart_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              line_q, done_q;
  logic              last;

  assign last = (cnt_q == CNT_W'(CLKS_PER_BIT-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
      line_q <= 1'b1; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (halt_i) begin
        // abort: drop frame, keep shift contents
        st_q <= ST_IDLE; cnt_q <= '0; bit_q <= '0; line_q <= 1'b1;
      end else begin
        case (st_q)
          ST_IDLE: if (start_i) begin
            st_q <= ST_START; sh_q <= data_i; line_q <= 1'b0; cnt_q <= '0;
          end
          ST_START: if (last) begin
            st_q <= ST_DATA; cnt_q <= '0; bit_q <= '0;
            line_q <= sh_q[0]; sh_q <= sh_q >> 1;
          end else cnt_q <= cnt_q + 1'b1;
          ST_DATA: if (last) begin
            cnt_q <= '0;
            if (bit_q == BIT_W'(DATA_W-1)) begin
              st_q <= ST_STOP; line_q <= 1'b1;
            end else begin
              line_q <= sh_q[0]; sh_q <= sh_q >> 1; bit_q <= bit_q + 1'b1;
            end
          end else cnt_q <= cnt_q + 1'b1;
          default: if (last) begin
            st_q <= ST_IDLE; done_q <= 1'b1; cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        endcase
      end
    end
  end

  assign line_o = line_q | halt_i;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  assert_line_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> line_q);
  assert_done_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(st_q == ST_STOP));
  assert_no_done_on_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !done_q);
endmodule

// File: rtl/uart_pm_rx.sv
`timescale 1ns/1ps
module uart_pm_rx import uart_pm_pkg::*; #(
  parameter int CLKS_PER_BIT = 8,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              line_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF  = (CLKS_PER_BIT / 2 > 0) ? CLKS_PER_BIT / 2 : 1;

  uart_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic              s1_q, s2_q, armed_q, valid_q;
  logic              last;

  assign last = (cnt_q == CNT_W'(CLKS_PER_BIT-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1; s2_q <= 1'b1;
    end else begin
      s1_q <= line_i; s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0; data_q <= '0;
      armed_q <= 1'b0; valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (halt_i) begin
        st_q <= ST_IDLE; cnt_q <= '0; bit_q <= '0; armed_q <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE:
            if (s2_q) armed_q <= 1'b1;
            else if (armed_q) begin st_q <= ST_START; cnt_q <= '0; end
          ST_START: if (cnt_q == CNT_W'(HALF-1)) begin
            cnt_q <= '0; bit_q <= '0;
            st_q  <= s2_q ? ST_IDLE : ST_DATA;
          end else cnt_q <= cnt_q + 1'b1;
          ST_DATA: if (last) begin
            cnt_q <= '0;
            sh_q  <= {s2_q, sh_q[DATA_W-1:1]};
            if (bit_q == BIT_W'(DATA_W-1)) st_q <= ST_STOP;
            else bit_q <= bit_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
          default: if (last) begin
            st_q <= ST_IDLE; cnt_q <= '0;
            if (s2_q) begin data_q <= sh_q; valid_q <= 1'b1; end
            else armed_q <= 1'b0;  // framing error: wait for high line
          end else cnt_q <= cnt_q + 1'b1;
        endcase
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign busy_o  = (st_q != ST_IDLE);

  assert_data_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(data_q));
  assert_no_valid_on_abort_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !valid_q);
endmodule

// File: rtl/uart_pm_wake.sv
`timescale 1ns/1ps
module uart_pm_wake (
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic line_i,
  output logic flag_o
);
  logic clr_n;
  assign clr_n = rst_ni & ~clr_i;

  // clocked by the receive line itself: works with module clock stopped
  always_ff @(negedge line_i or negedge clr_n) begin
    if (!clr_n)     flag_o <= 1'b0;
    else if (arm_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/uart_pm_top.sv
`timescale 1ns/1ps
module uart_pm_top #(
  parameter int CLKS_PER_BIT = 8,
  parameter int DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sleep_i,
  input  logic              idle_i,
  input  logic              stop_in_idle_i,
  input  logic              wake_en_i,
  input  logic              rx_irq_en_i,
  input  logic              wake_clr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_start_i,
  output logic              tx_o,
  output logic              tx_busy_o,
  output logic              tx_done_o,
  input  logic              rx_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_busy_o,
  output logic              wake_irq_o,
  output logic              wake_o
);
  logic halt;
  assign halt = sleep_i | ~en_i | (idle_i & stop_in_idle_i);

  uart_pm_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .halt_i(halt), .start_i(tx_start_i), .data_i(tx_data_i),
    .line_o(tx_o), .busy_o(tx_busy_o), .done_o(tx_done_o));

  uart_pm_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .halt_i(halt), .line_i(rx_i),
    .data_o(rx_data_o), .valid_o(rx_valid_o), .busy_o(rx_busy_o));

  uart_pm_wake u_wake (
    .rst_ni, .clr_i(wake_clr_i), .arm_i(en_i & wake_en_i & sleep_i),
    .line_i(rx_i), .flag_o(wake_irq_o));

  assign wake_o = wake_irq_o & rx_irq_en_i & en_i;

  assert_halt_clears_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> (!tx_busy_o && !rx_busy_o));
  assert_tx_line_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> tx_o);
endmodule

// File: tb/sim_uart_pm_top.sv
`timescale 1ns/1ps
module sim_uart_pm_top;
  localparam int CPB = 8;
  localparam int NV  = 5;
  // {stop bit, byte}; stop 0 expects the frame to be dropped
  localparam logic [8:0] VEC [NV] = '{9'h155, 9'h1A3, 9'h100, 9'h1FF, 9'h06E};

  logic clk = 0, clk_run = 1, rst_n = 0;
  logic en = 1, sleep = 0, idle = 0, sii = 0, wake_en = 0, rx_irq_en = 0, wake_clr = 0;
  logic [7:0] tx_data = 0;
  logic tx_start = 0, rx = 1;
  logic tx_o, tx_busy, tx_done, rx_valid, rx_busy, wake_irq, wake;
  logic [7:0] rx_data;
  int tests = 0, fails = 0, done_n = 0, valid_n = 0;

  always begin #2.5; if (clk_run) clk = ~clk; end

  uart_pm_top #(.CLKS_PER_BIT(CPB), .DATA_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sleep_i(sleep), .idle_i(idle),
    .stop_in_idle_i(sii), .wake_en_i(wake_en), .rx_irq_en_i(rx_irq_en),
    .wake_clr_i(wake_clr), .tx_data_i(tx_data), .tx_start_i(tx_start),
    .tx_o(tx_o), .tx_busy_o(tx_busy), .tx_done_o(tx_done), .rx_i(rx),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_busy_o(rx_busy),
    .wake_irq_o(wake_irq), .wake_o(wake));

  always @(negedge clk) begin
    if (tx_done) done_n++;
    if (rx_valid) valid_n++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rx_bits(input logic [9:0] frame, input int n);
    for (int b = 0; b < n; b++) begin
      rx = frame[b];
      repeat (CPB) @(negedge clk);
    end
  endtask

  task automatic rx_send(input logic [7:0] d, input logic stp);
    rx_bits({stp, d, 1'b0}, 10);
    rx = 1;
    repeat (2*CPB) @(negedge clk);
  endtask

  task automatic tx_check(input logic [7:0] d, input string req);
    logic [9:0] f;
    int d0;
    f = {1'b1, d, 1'b0};
    d0 = done_n;
    tx_data = d; tx_start = 1;
    @(negedge clk); tx_start = 0;
    repeat (CPB/2) @(negedge clk);
    for (int b = 0; b < 10; b++) begin
      chk(req, tx_o, f[b]);
      repeat (CPB) @(negedge clk);
    end
    chk(req, done_n - d0, 1);
    chk(req, tx_busy, 0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v0, d0;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {tx_o, tx_busy, tx_done, rx_busy, rx_valid, wake_irq, wake}, 7'b1000000);
    chk("R1", rx_data, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 R3 vector walk
    for (int i = 0; i < NV; i++) begin
      v0 = valid_n; keep = rx_data;
      rx_send(VEC[i][7:0], VEC[i][8]);
      chk("R3", valid_n - v0, VEC[i][8] ? 1 : 0);
      chk("R3", rx_data, VEC[i][8] ? VEC[i][7:0] : keep);
      tx_check(VEC[i][7:0], "R2");
    end
    // line is high now; receiver re-arms after framing error (R11)
    v0 = valid_n;
    rx_send(8'h5A, 1'b1);
    chk("R11", rx_data, 8'h5A);

    // R4 R5: abort tx by sleep
    d0 = done_n;
    tx_data = 8'h00; tx_start = 1; @(negedge clk); tx_start = 0;
    repeat (2*CPB) @(negedge clk);
    sleep = 1; #1;
    chk("R4", tx_o, 1);
    @(negedge clk);
    chk("R4", tx_busy, 0);
    // R12 start ignored while halted
    tx_start = 1; @(negedge clk); tx_start = 0; @(negedge clk);
    chk("R12", tx_busy, 0);
    sleep = 0;
    repeat (12*CPB) @(negedge clk);
    chk("R5", done_n - d0, 0);

    // R5 R6: abort rx by sleep
    v0 = valid_n; keep = rx_data;
    rx_bits({1'b1, 8'h96, 1'b0}, 4);
    chk("R4", rx_busy, 1);
    sleep = 1;
    @(negedge clk);
    chk("R4", rx_busy, 0);
    rx_bits({1'b1, 8'h96, 1'b0} >> 4, 6);
    rx = 1; repeat (2*CPB) @(negedge clk);
    sleep = 0; repeat (2*CPB) @(negedge clk);
    chk("R5", valid_n - v0, 0);
    chk("R6", rx_data, keep);

    // R11: line already low when halt ends
    sleep = 1; rx = 0; repeat (CPB) @(negedge clk);
    sleep = 0; repeat (3*CPB) @(negedge clk);
    chk("R11", rx_busy, 0);
    rx = 1; repeat (2*CPB) @(negedge clk);
    chk("R11", valid_n - v0, 0);
    rx_send(8'h3C, 1'b1);
    chk("R11", rx_data, 8'h3C);

    // R7: idle with stop_in_idle 0 keeps running
    idle = 1; sii = 0;
    tx_check(8'hC5, "R7");
    v0 = valid_n;
    rx_send(8'h81, 1'b1);
    chk("R7", valid_n - v0, 1);
    // R4: idle with stop_in_idle 1 halts
    d0 = done_n;
    sii = 0; tx_data = 8'h00; tx_start = 1; @(negedge clk); tx_start = 0;
    repeat (CPB) @(negedge clk);
    sii = 1; #1;
    chk("R4", tx_o, 1);
    repeat (12*CPB) @(negedge clk);
    chk("R5", done_n - d0, 0);
    idle = 0; sii = 0;
    // R4: module disabled
    en = 0; tx_start = 1; @(negedge clk); tx_start = 0; @(negedge clk);
    chk("R12", tx_busy, 0);
    en = 1;
    // R12: start ignored while busy
    d0 = done_n;
    tx_data = 8'hF0; tx_start = 1; @(negedge clk); tx_start = 0;
    repeat (3*CPB) @(negedge clk);
    tx_data = 8'h0F; tx_start = 1; @(negedge clk); tx_start = 0;
    repeat (20*CPB) @(negedge clk);
    chk("R12", done_n - d0, 1);

    // R8 R9: wake with clock stopped
    wake_en = 1; rx_irq_en = 1; sleep = 1;
    repeat (2) @(negedge clk);
    clk_run = 0; #20;
    rx = 0; #2;
    chk("R8", wake_irq, 1);
    chk("R9", wake, 1);
    rx = 1; #2;
    wake_clr = 1; #1;
    chk("R10", wake_irq, 0);
    wake_clr = 0;
    // R8 flag set even with interrupt disabled; R9 no wake
    rx_irq_en = 0;
    rx = 0; #2;
    chk("R8", wake_irq, 1);
    chk("R9", wake, 0);
    rx = 1; wake_clr = 1; #1; wake_clr = 0;
    // R10 not armed
    wake_en = 0;
    rx = 0; #2;
    chk("R10", wake_irq, 0);
    rx = 1; #2;
    clk_run = 1;
    repeat (2) @(negedge clk);
    sleep = 0;
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule